// File: doc/BRIEF.md
# Thermal Monitor Control and Interrupt Register Bank

This block is the byte-wide register bank of a temperature-monitor and fan-control device. It sits behind a simple parallel host port with an address, write data, a write strobe, a read strobe and registered read data. It holds the control byte and the interrupt status and mask. It also holds two pairs of temperature trip thresholds, one user-programmable pair and one default pair. Its outputs are the run/standby state, an active-low interrupt, the fan-stop request, the conditioned GPI level and the ambient and remote trip thresholds currently in force.

Event detectors elsewhere in the chip report one-cycle pulses, and each pulse latches a status bit. The GPI input, optionally inverted, latches the top status bit. A thermal-alarm input forces the fan request into its released state. The control byte has several special bits: a lock bit that can only be set once, which freezes the programmable thresholds and selects them; a self-clearing soft-reset bit that covers only the control and interrupt registers; and an interrupt-quiet bit that silences the pin without touching the status.

Top module: `thermon_regbank`

## Requirements
- R1: After `aux_rst`, the control byte (address 0x40) reads 0x25. Status (0x41), mask (0x43) and the status copy (0x4C) read 0x00. `run_o`=1, `int_n_o`=1 and `fan_stop_n_o`=1. The ambient and remote thresholds in force are the default-byte reset values (0x3C and 0x50).
- R2: Control bit 0 drives `run_o` (1 run, 0 standby). Clearing it does not release an interrupt that is already low.
- R3: `int_n_o` is low exactly when control bit 1 (enable) is 1, control bit 2 (quiet) is 0, and some status bit whose mask bit is 0 is set. While bit 2 is 1 the pin stays high and the status is unchanged. Mask bit i blocks status bit i.
- R4: A pulse on `evt_pulse[i]` sets status bit i (i = 0..6). Status bit 7 is set on every cycle in which the conditioned GPI level is 1. Reading 0x41 returns the status and clears it, and a set in the same cycle wins. Reading 0x4C returns the same bits without clearing them.
- R5: Control bit 6 inverts GPI, so `gpi_lvl_o` = `gpi_in` XOR bit 6. This level feeds status bit 7.
- R6: Control bit 3 (lock) is write-once. Once it is 1, writing 0 to it has no effect, and only `aux_rst` clears it. While it is 1, writes to 0x13 and 0x14 are ignored.
- R7: With the lock bit at 0, the ambient and remote thresholds in force are the default bytes at 0x17 and 0x18. With the lock bit at 1, they are the programmable bytes at 0x13 and 0x14. All four bytes read back at their addresses.
- R8: Writing 1 to control bit 4 restores the control byte to its reset value while keeping the lock bit, and clears status and mask. Bit 4 always reads 0, and the threshold bytes are unchanged.
- R9: Control bit 5 drives `fan_stop_n_o`, where 0 requests fan stop. Any cycle with `therm_in` high forces the bit to 1, and a read of 0x40 shows the forced value.
- R10: Control bit 7 reads 0 whatever is written to it. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aux_rst | input | 1 | Synchronous active-high auxiliary reset; restores every register including the lock |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_rdata | output | 8 | Read data, valid the cycle after the strobe |
| therm_in | input | 1 | Thermal alarm, active high |
| gpi_in | input | 1 | General-purpose input |
| evt_pulse | input | 7 | One-cycle event pulses feeding status bits 0..6 |
| run_o | output | 1 | 1 run, 0 standby |
| int_n_o | output | 1 | Interrupt, active low |
| fan_stop_n_o | output | 1 | 0 requests fan stop, 1 releases |
| gpi_lvl_o | output | 1 | GPI after optional inversion |
| amb_trip_o | output | 8 | Ambient threshold in force |
| rmt_trip_o | output | 8 | Remote threshold in force |

## Verification
The assertions assume that `therm_in`, `gpi_in` and `evt_pulse` are already synchronous to `clk`. They also assume the host never raises `host_wr` and `host_rd` in the same cycle. The lock and threshold properties are only meaningful between `aux_rst` pulses. The bench drives every input on the falling edge, gives each strobe exactly one cycle and keeps write and read strobes apart. It reaches the read-clear versus event-set collision only through a single deliberate same-cycle overlap.

// File: rtl/thermon_pkg.sv
package thermon_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CFG     = 8'h40;
  localparam logic [ADDR_W-1:0] A_STAT    = 8'h41;
  localparam logic [ADDR_W-1:0] A_MASK    = 8'h43;
  localparam logic [ADDR_W-1:0] A_MIRR    = 8'h4C;
  localparam logic [ADDR_W-1:0] A_AMB_PRG = 8'h13;
  localparam logic [ADDR_W-1:0] A_RMT_PRG = 8'h14;
  localparam logic [ADDR_W-1:0] A_AMB_DEF = 8'h17;
  localparam logic [ADDR_W-1:0] A_RMT_DEF = 8'h18;

  localparam int NUM_TRIP = 4;
  // slot order: ambient prog, remote prog, ambient default, remote default
  localparam logic [ADDR_W-1:0] TRIP_ADDR [NUM_TRIP] =
    '{A_AMB_PRG, A_RMT_PRG, A_AMB_DEF, A_RMT_DEF};

  localparam int B_RUN  = 0;
  localparam int B_IEN  = 1;
  localparam int B_QUIET = 2;
  localparam int B_LOCK = 3;
  localparam int B_SRST = 4;
  localparam int B_FAN  = 5;
  localparam int B_GINV = 6;

  typedef struct packed {
    logic ginv;
    logic fan;
    logic lock;
    logic quiet;
    logic ien;
    logic run;
  } cfg_t;

  localparam cfg_t CFG_PON = '{ginv: 1'b0, fan: 1'b1, lock: 1'b0,
                               quiet: 1'b1, ien: 1'b0, run: 1'b1};

  function automatic logic [DATA_W-1:0] cfg_to_byte(input cfg_t c);
    logic [DATA_W-1:0] b;
    b = '0;
    b[B_RUN]   = c.run;
    b[B_IEN]   = c.ien;
    b[B_QUIET] = c.quiet;
    b[B_LOCK]  = c.lock;
    b[B_FAN]   = c.fan;
    b[B_GINV]  = c.ginv;
    return b;
  endfunction
endpackage

// File: rtl/thermon_cfg.sv
module thermon_cfg
  import thermon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              therm,
  output cfg_t              cfg_q,
  output logic              soft_rst
);
  logic unused_wbits;
  assign unused_wbits = wdata[DATA_W-1];

  assign soft_rst = wr_en && wdata[B_SRST];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_PON;
    end else if (soft_rst) begin
      cfg_q <= '{ginv: CFG_PON.ginv, fan: CFG_PON.fan, lock: cfg_q.lock,
                 quiet: CFG_PON.quiet, ien: CFG_PON.ien, run: CFG_PON.run};
    end else if (wr_en) begin
      cfg_q.run   <= wdata[B_RUN];
      cfg_q.ien   <= wdata[B_IEN];
      cfg_q.quiet <= wdata[B_QUIET];
      cfg_q.lock  <= cfg_q.lock | wdata[B_LOCK];
      cfg_q.fan   <= wdata[B_FAN] | therm;
      cfg_q.ginv  <= wdata[B_GINV];
    end else if (therm) begin
      cfg_q.fan <= 1'b1;
    end
  end

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_q.lock |=> cfg_q.lock);

  // R9
  therm_fan_chk: assert property (@(posedge clk) disable iff (rst)
    therm |=> cfg_q.fan);

  // R8
  srst_restore_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cfg_q.run && cfg_q.quiet && !cfg_q.ien && cfg_q.fan &&
                  !cfg_q.ginv && (cfg_q.lock == $past(cfg_q.lock))));
endmodule

// File: rtl/thermon_irq.sv
module thermon_irq
  import thermon_pkg::*;
#(
  parameter int NUM_EVT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clr,
  input  logic [NUM_EVT-1:0] evt,
  input  logic              gpi_lvl,
  input  logic              ien,
  input  logic              quiet,
  output logic [NUM_EVT:0]  status_q,
  output logic [NUM_EVT:0]  mask_q,
  output logic              int_n_q
);
  localparam int STAT_W = NUM_EVT + 1;

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] kept;
  logic              pending;

  assign set_vec = {gpi_lvl, evt};
  assign kept    = rd_clr ? '0 : status_q;
  assign pending = |(status_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= kept | set_vec;
      if (mask_wr) mask_q <= wdata[STAT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) int_n_q <= 1'b1;
    else     int_n_q <= !(ien && !quiet && pending);
  end

  // R3
  quiet_pin_chk: assert property (@(posedge clk) disable iff (rst)
    quiet |=> int_n_q);

  // R3
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~mask_q) == '0) |=> int_n_q);

  // R4
  evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ((|evt) && !soft_rst) |=>
      ((status_q[NUM_EVT-1:0] & $past(evt)) == $past(evt)));
endmodule

// File: rtl/thermon_trip.sv
module thermon_trip
  import thermon_pkg::*;
#(
  parameter logic [DATA_W-1:0] PRG_INIT     = 8'h00,
  parameter logic [DATA_W-1:0] AMB_DEF_INIT = 8'h3C,
  parameter logic [DATA_W-1:0] RMT_DEF_INIT = 8'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock,
  output logic [DATA_W-1:0] trip_q [NUM_TRIP],
  output logic [DATA_W-1:0] amb_o,
  output logic [DATA_W-1:0] rmt_o
);
  localparam logic [DATA_W-1:0] INIT [NUM_TRIP] =
    '{PRG_INIT, PRG_INIT, AMB_DEF_INIT, RMT_DEF_INIT};

  for (genvar g = 0; g < NUM_TRIP; g++) begin : g_slot
    // slots 0 and 1 are the programmable pair, frozen by the lock
    localparam bit IS_PRG = (g < 2);
    logic hit;
    assign hit = wr_en && (addr == TRIP_ADDR[g]) && !(IS_PRG && lock);
    always_ff @(posedge clk) begin
      if (rst)      trip_q[g] <= INIT[g];
      else if (hit) trip_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amb_o <= AMB_DEF_INIT;
      rmt_o <= RMT_DEF_INIT;
    end else begin
      amb_o <= lock ? trip_q[0] : trip_q[2];
      rmt_o <= lock ? trip_q[1] : trip_q[3];
    end
  end

  // R6
  prog_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable({trip_q[1], trip_q[0]}));
endmodule

// File: rtl/thermon_regbank.sv
module thermon_regbank
  import thermon_pkg::*;
#(
  parameter int                NUM_EVT      = 7,
  parameter logic [DATA_W-1:0] PRG_INIT     = 8'h00,
  parameter logic [DATA_W-1:0] AMB_DEF_INIT = 8'h3C,
  parameter logic [DATA_W-1:0] RMT_DEF_INIT = 8'h50
) (
  input  logic              clk,
  input  logic              aux_rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              therm_in,
  input  logic              gpi_in,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic              run_o,
  output logic              int_n_o,
  output logic              fan_stop_n_o,
  output logic              gpi_lvl_o,
  output logic [DATA_W-1:0] amb_trip_o,
  output logic [DATA_W-1:0] rmt_trip_o
);
  localparam int STAT_W = NUM_EVT + 1;

  cfg_t              cfg_q;
  logic              soft_rst;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;
  logic [DATA_W-1:0] trip_q [NUM_TRIP];
  logic [DATA_W-1:0] rd_mux;
  logic              cfg_wr, mask_wr, stat_clr;

  assign cfg_wr   = host_wr && (host_addr == A_CFG);
  assign mask_wr  = host_wr && (host_addr == A_MASK);
  assign stat_clr = host_rd && (host_addr == A_STAT);

  thermon_cfg u_cfg (
    .clk(clk), .rst(aux_rst), .wr_en(cfg_wr), .wdata(host_wdata),
    .therm(therm_in), .cfg_q(cfg_q), .soft_rst(soft_rst)
  );

  thermon_irq #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk(clk), .rst(aux_rst), .soft_rst(soft_rst), .mask_wr(mask_wr),
    .wdata(host_wdata), .rd_clr(stat_clr), .evt(evt_pulse),
    .gpi_lvl(gpi_lvl_o), .ien(cfg_q.ien), .quiet(cfg_q.quiet),
    .status_q(status_q), .mask_q(mask_q), .int_n_q(int_n_o)
  );

  thermon_trip #(
    .PRG_INIT(PRG_INIT), .AMB_DEF_INIT(AMB_DEF_INIT), .RMT_DEF_INIT(RMT_DEF_INIT)
  ) u_trip (
    .clk(clk), .rst(aux_rst), .wr_en(host_wr), .addr(host_addr),
    .wdata(host_wdata), .lock(cfg_q.lock), .trip_q(trip_q),
    .amb_o(amb_trip_o), .rmt_o(rmt_trip_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (host_addr)
      A_CFG:            rd_mux = cfg_to_byte(cfg_q);
      A_STAT, A_MIRR:   rd_mux[STAT_W-1:0] = status_q;
      A_MASK:           rd_mux[STAT_W-1:0] = mask_q;
      A_AMB_PRG:        rd_mux = trip_q[0];
      A_RMT_PRG:        rd_mux = trip_q[1];
      A_AMB_DEF:        rd_mux = trip_q[2];
      A_RMT_DEF:        rd_mux = trip_q[3];
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (aux_rst) begin
      host_rdata   <= '0;
      run_o        <= CFG_PON.run;
      fan_stop_n_o <= CFG_PON.fan;
      gpi_lvl_o    <= 1'b0;
    end else begin
      if (host_rd) host_rdata <= rd_mux;
      run_o        <= cfg_q.run;
      fan_stop_n_o <= cfg_q.fan;
      gpi_lvl_o    <= gpi_in ^ cfg_q.ginv;
    end
  end

  // R10
  cfg_msb_chk: assert property (@(posedge clk) disable iff (aux_rst)
    (host_rd && host_addr == A_CFG) |=> !host_rdata[DATA_W-1]);

  // R4
  mirror_keep_chk: assert property (@(posedge clk) disable iff (aux_rst)
    (host_rd && host_addr == A_MIRR && !soft_rst) |=>
      ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: tb/sim_thermon_regbank.sv
module sim_thermon_regbank;
  logic       clk = 1'b0;
  logic       aux_rst = 1'b1;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       therm_in = 1'b0, gpi_in = 1'b0;
  logic [6:0] evt_pulse = '0;
  logic       run_o, int_n_o, fan_stop_n_o, gpi_lvl_o;
  logic [7:0] amb_trip_o, rmt_trip_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  thermon_regbank u0 (
    .clk(clk), .aux_rst(aux_rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .therm_in(therm_in), .gpi_in(gpi_in), .evt_pulse(evt_pulse),
    .run_o(run_o), .int_n_o(int_n_o), .fan_stop_n_o(fan_stop_n_o),
    .gpi_lvl_o(gpi_lvl_o), .amb_trip_o(amb_trip_o), .rmt_trip_o(rmt_trip_o)
  );

  // {is_read, addr, wdata, expected read}
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h40, 8'h00, 8'h25},
    {1'b1, 8'h41, 8'h00, 8'h00},
    {1'b1, 8'h43, 8'h00, 8'h00},
    {1'b1, 8'h4C, 8'h00, 8'h00},
    {1'b1, 8'h17, 8'h00, 8'h3C},
    {1'b1, 8'h18, 8'h00, 8'h50},
    {1'b0, 8'h43, 8'hF0, 8'h00},
    {1'b1, 8'h43, 8'h00, 8'hF0},
    {1'b0, 8'h17, 8'h3A, 8'h00},
    {1'b1, 8'h17, 8'h00, 8'h3A},
    {1'b0, 8'h13, 8'h55, 8'h00},
    {1'b1, 8'h13, 8'h00, 8'h55},
    {1'b0, 8'h40, 8'hA7, 8'h00},
    {1'b1, 8'h40, 8'h00, 8'h27},
    {1'b1, 8'h22, 8'h00, 8'h00},
    {1'b1, 8'h3E, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] q);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    q = host_rdata;
  endtask

  task automatic pulse_evt(input int i);
    @(negedge clk);
    evt_pulse[i] = 1'b1;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    aux_rst = 1'b1;
    settle(2);
    aux_rst = 1'b0;
    settle(1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    logic [7:0] q;
    settle(3);
    aux_rst = 1'b0;
    settle(2);
    // R1 reset state at the ports
    chk("R1 run_o", {7'd0, run_o}, 8'h01);
    chk("R1 int_n_o", {7'd0, int_n_o}, 8'h01);
    chk("R1 fan_stop_n_o", {7'd0, fan_stop_n_o}, 8'h01);
    chk("R1 amb_trip_o", amb_trip_o, 8'h3C);
    chk("R1 rmt_trip_o", rmt_trip_o, 8'h50);

    // table: R1 reset reads, R7 byte access, R10 bit 7 and unmapped
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        rd(VEC[i][23:16], q);
        chk($sformatf("table R1 R7 R10 entry %0d", i), q, VEC[i][7:0]);
      end else begin
        wr(VEC[i][23:16], VEC[i][15:8]);
      end
    end

    do_reset();
    // R3 interrupt raised
    wr(8'h43, 8'h00);
    wr(8'h40, 8'h23);
    pulse_evt(2);
    settle(2);
    chk("R3 int low", {7'd0, int_n_o}, 8'h00);
    rd(8'h4C, q);
    chk("R4 copy read", q, 8'h04);
    settle(1);
    chk("R4 copy no clear int", {7'd0, int_n_o}, 8'h00);
    // R3 quiet bit
    wr(8'h40, 8'h27);
    settle(2);
    chk("R3 quiet pin high", {7'd0, int_n_o}, 8'h01);
    rd(8'h4C, q);
    chk("R3 quiet keeps status", q, 8'h04);
    // R2 standby keeps interrupt
    wr(8'h40, 8'h22);
    settle(2);
    chk("R2 run_o standby", {7'd0, run_o}, 8'h00);
    chk("R2 int stays low", {7'd0, int_n_o}, 8'h00);
    // R4 clear on read
    rd(8'h41, q);
    chk("R4 status read", q, 8'h04);
    rd(8'h4C, q);
    chk("R4 status cleared", q, 8'h00);
    settle(1);
    chk("R4 int released", {7'd0, int_n_o}, 8'h01);
    // R3 mask
    wr(8'h43, 8'h08);
    pulse_evt(3);
    settle(2);
    chk("R3 masked int", {7'd0, int_n_o}, 8'h01);
    rd(8'h41, q);
    chk("R3 masked status", q, 8'h08);

    // R5 GPI
    gpi_in = 1'b1;
    settle(3);
    chk("R5 gpi plain", {7'd0, gpi_lvl_o}, 8'h01);
    rd(8'h4C, q);
    chk("R5 gpi status bit7", q, 8'h80);
    wr(8'h40, 8'h62);
    settle(2);
    chk("R5 gpi inverted", {7'd0, gpi_lvl_o}, 8'h00);
    rd(8'h41, q);
    rd(8'h4C, q);
    chk("R5 inverted no set", q, 8'h00);
    wr(8'h40, 8'h22);
    gpi_in = 1'b0;
    settle(3);
    rd(8'h41, q);

    // R9 fan and THERM
    wr(8'h40, 8'h02);
    settle(2);
    chk("R9 fan stop request", {7'd0, fan_stop_n_o}, 8'h00);
    rd(8'h40, q);
    chk("R9 cfg fan 0", q, 8'h02);
    @(negedge clk); therm_in = 1'b1;
    @(negedge clk); therm_in = 1'b0;
    settle(2);
    chk("R9 therm forced release", {7'd0, fan_stop_n_o}, 8'h01);
    rd(8'h40, q);
    chk("R9 cfg fan forced", q, 8'h22);

    // R7 and R6 trip selection and lock
    wr(8'h13, 8'h41); wr(8'h14, 8'h62); wr(8'h17, 8'h30); wr(8'h18, 8'h48);
    settle(2);
    chk("R7 amb default", amb_trip_o, 8'h30);
    chk("R7 rmt default", rmt_trip_o, 8'h48);
    wr(8'h40, 8'h28);
    settle(2);
    chk("R7 amb prog", amb_trip_o, 8'h41);
    chk("R7 rmt prog", rmt_trip_o, 8'h62);
    wr(8'h13, 8'h11);
    rd(8'h13, q);
    chk("R6 prog frozen", q, 8'h41);
    wr(8'h40, 8'h20);
    rd(8'h40, q);
    chk("R6 lock sticky", q, 8'h28);

    // R8 soft reset
    wr(8'h43, 8'h33);
    pulse_evt(0);
    wr(8'h40, 8'h10);
    rd(8'h40, q);
    chk("R8 cfg restored", q, 8'h2D);
    rd(8'h43, q);
    chk("R8 mask cleared", q, 8'h00);
    rd(8'h4C, q);
    chk("R8 status cleared", q, 8'h00);
    rd(8'h14, q);
    chk("R8 trip untouched", q, 8'h62);

    // R6 auxiliary reset releases lock
    do_reset();
    rd(8'h40, q);
    chk("R6 aux clears lock", q, 8'h25);
    settle(1);
    chk("R6 defaults back", amb_trip_o, 8'h3C);
    rd(8'h13, q);
    chk("R6 prog reset", q, 8'h00);

    // R4 set wins over read-clear in the same cycle
    @(negedge clk);
    host_addr = 8'h41; host_rd = 1'b1; evt_pulse[1] = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; evt_pulse = '0;
    rd(8'h4C, q);
    chk("R4 set beats clear", q, 8'h02);

    done = 1'b1;
    summary();
  end
endmodule